// File: doc/BRIEF.md
# Rough-Set Core Attribute Calculator

This block holds a small decision table in registers and, on request, finds its core: the condition attributes that no reduct can drop. Each row of the table is one object with a fixed number of condition attributes, each a small unsigned value, plus a decision value. Software or a neighbouring block fills the rows one at a time through a write port, then pulses `start`.

For every pair of rows whose decisions differ, a bank of per-attribute comparators builds a discernibility mask. Each mask has one bit per attribute, set where the two rows disagree. An exactly-one-hot detector examines each mask. Every mask with a single set bit names an attribute that alone separates that pair, and the union of all such masks is the core. All pairs are evaluated at once in combinational logic, so the result is captured on the `start` edge. A pair with different decisions but identical conditions makes the table inconsistent, and a sticky flag records it.

Top module: `rsc_core_calc`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `core_mask`, `done` and `inconsistent` are zero, and every stored row reads as all-zero conditions with decision zero.
- R2: A cycle with `wr_en` high stores `wr_cond` and `wr_dec` in row `wr_idx`. Attribute a of a row occupies bits `[a*VAL_W +: VAL_W]` of `wr_cond`.
- R3: For each pair of rows with different decisions, the discernibility mask has bit a set exactly when the two rows hold different values for attribute a.
- R4: After an evaluation, `core_mask` bit a is 1 exactly when at least one discernibility mask equals the single bit a.
- R5: Pairs whose decision values are equal contribute nothing to `core_mask` or `inconsistent`.
- R6: A discernibility mask with two or more bits set contributes nothing to `core_mask`.
- R7: A `start` sampled high at a rising edge updates `core_mask` at that edge and raises `done` for exactly the following cycle. `core_mask` holds its value until the next `start`.
- R8: An all-zero discernibility mask adds no core bit and sets `inconsistent`, which stays high until reset.
- R9: When `wr_en` and `start` are high on the same edge, the evaluation uses the table as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Row write strobe |
| wr_idx | input | IDX_W | Row written |
| wr_cond | input | NUM_ATTR*VAL_W | Condition values of the row, attribute 0 in the low bits |
| wr_dec | input | DEC_W | Decision value of the row |
| start | input | 1 | Evaluate the stored table |
| core_mask | output | NUM_ATTR | One bit per attribute in the core |
| done | output | 1 | One-cycle pulse after an evaluation |
| inconsistent | output | 1 | Sticky: some differing-decision pair had equal conditions |

## Verification
Random tables rarely produce core bits. Two random rows disagree on most attributes, so masks with exactly one bit almost never appear, and identical condition rows with different decisions are rarer still. The bench therefore builds most tables from a random base row, with each object a copy that has one or two attributes overwritten. This yields many single-bit, double-bit and empty masks, which are checked against a pairwise model. Dedicated tables cover an empty core, an inconsistent pair, and a write colliding with `start`.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    localparam int DEF_NUM_OBJ  = 8;
    localparam int DEF_NUM_ATTR = 8;
    localparam int DEF_VAL_W    = 2;
    localparam int DEF_DEC_W    = 1;

    // classification of one object pair
    typedef struct packed {
        logic active;  // decisions differ
        logic single;  // mask has exactly one bit
        logic empty;   // mask has no bit
    } pair_flags_t;
endpackage

// File: rtl/rsc_table_store.sv
module rsc_table_store #(
    parameter int NUM_OBJ  = 8,
    parameter int ROW_W    = 16,
    parameter int DEC_W    = 1,
    parameter int IDX_W    = 3
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [ROW_W-1:0]                  wr_cond,
    input  logic [DEC_W-1:0]                  wr_dec,
    output logic [NUM_OBJ-1:0][ROW_W-1:0]     cond_o,
    output logic [NUM_OBJ-1:0][DEC_W-1:0]     dec_o
);
    for (genvar r = 0; r < NUM_OBJ; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                cond_o[r] <= '0;
                dec_o[r]  <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(r))) begin
                cond_o[r] <= wr_cond;
                dec_o[r]  <= wr_dec;
            end
        end
    end
endmodule

// File: rtl/rsc_pair_cmp.sv
module rsc_pair_cmp #(
    parameter int NUM_ATTR = 8,
    parameter int VAL_W    = 2,
    parameter int DEC_W    = 1,
    localparam int ROW_W   = NUM_ATTR * VAL_W
) (
    input  logic [ROW_W-1:0]    row_a,
    input  logic [ROW_W-1:0]    row_b,
    input  logic [DEC_W-1:0]    dec_a,
    input  logic [DEC_W-1:0]    dec_b,
    output logic [NUM_ATTR-1:0] diff_mask,
    output logic                dec_differ
);
    for (genvar a = 0; a < NUM_ATTR; a++) begin : g_attr
        assign diff_mask[a] = (row_a[a*VAL_W +: VAL_W] != row_b[a*VAL_W +: VAL_W]);
    end
    assign dec_differ = (dec_a != dec_b);
endmodule

// File: rtl/rsc_onehot_det.sv
module rsc_onehot_det #(
    parameter int W = 8
) (
    input  logic [W-1:0] vec,
    output logic         single,
    output logic         empty
);
    // ripple of "seen at least one" / "seen at least two"
    logic [W:0] seen1, seen2;
    assign seen1[0] = 1'b0;
    assign seen2[0] = 1'b0;
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign seen2[b+1] = seen2[b] | (seen1[b] & vec[b]);
        assign seen1[b+1] = seen1[b] | vec[b];
    end
    assign single = seen1[W] & ~seen2[W];
    assign empty  = ~seen1[W];
endmodule

// File: rtl/rsc_core_calc.sv
module rsc_core_calc
    import rsc_pkg::*;
#(
    parameter int NUM_OBJ  = DEF_NUM_OBJ,
    parameter int NUM_ATTR = DEF_NUM_ATTR,
    parameter int VAL_W    = DEF_VAL_W,
    parameter int DEC_W    = DEF_DEC_W,
    localparam int IDX_W   = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1,
    localparam int ROW_W   = NUM_ATTR * VAL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [ROW_W-1:0]    wr_cond,
    input  logic [DEC_W-1:0]    wr_dec,
    input  logic                start,
    output logic [NUM_ATTR-1:0] core_mask,
    output logic                done,
    output logic                inconsistent
);
    logic [NUM_OBJ-1:0][ROW_W-1:0] cond_q;
    logic [NUM_OBJ-1:0][DEC_W-1:0] dec_q;

    rsc_table_store #(
        .NUM_OBJ(NUM_OBJ), .ROW_W(ROW_W), .DEC_W(DEC_W), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_cond(wr_cond), .wr_dec(wr_dec), .cond_o(cond_q), .dec_o(dec_q)
    );

    logic [NUM_ATTR-1:0] pair_mask  [NUM_OBJ][NUM_OBJ];
    pair_flags_t         pair_flags [NUM_OBJ][NUM_OBJ];

    for (genvar i = 0; i < NUM_OBJ; i++) begin : g_i
        for (genvar j = 0; j < NUM_OBJ; j++) begin : g_j
            if (j > i) begin : g_pair
                logic dec_ne, one, none;
                rsc_pair_cmp #(
                    .NUM_ATTR(NUM_ATTR), .VAL_W(VAL_W), .DEC_W(DEC_W)
                ) u_cmp (
                    .row_a(cond_q[i]), .row_b(cond_q[j]),
                    .dec_a(dec_q[i]), .dec_b(dec_q[j]),
                    .diff_mask(pair_mask[i][j]), .dec_differ(dec_ne)
                );
                rsc_onehot_det #(.W(NUM_ATTR)) u_det (
                    .vec(pair_mask[i][j]), .single(one), .empty(none)
                );
                assign pair_flags[i][j] = '{active: dec_ne, single: one, empty: none};
            end else begin : g_none
                assign pair_mask[i][j]  = '0;
                assign pair_flags[i][j] = '0;
            end
        end
    end

    logic [NUM_ATTR-1:0] core_d;
    logic                empty_d;

    always_comb begin
        core_d  = '0;
        empty_d = 1'b0;
        for (int i = 0; i < NUM_OBJ; i++) begin
            for (int j = 0; j < NUM_OBJ; j++) begin
                if (pair_flags[i][j].active) begin
                    if (pair_flags[i][j].single) core_d = core_d | pair_mask[i][j];
                    if (pair_flags[i][j].empty)  empty_d = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_mask    <= '0;
            done         <= 1'b0;
            inconsistent <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                core_mask <= core_d;
                if (empty_d) inconsistent <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rsc_core_chk.sv
module rsc_core_chk #(
    parameter int NUM_ATTR = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                done,
    input logic                inconsistent,
    input logic [NUM_ATTR-1:0] core_mask
);
    AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (rst)
        start |=> done);                                   // R7
    AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);                                 // R7
    AST_CORE_HELD: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(core_mask));                    // R7
    AST_INCONS_STICKY: assert property (@(posedge clk) disable iff (rst)
        inconsistent |=> inconsistent);                    // R8
    AST_INCONS_ON_EVAL: assert property (@(posedge clk) disable iff (rst)
        !start |=> !$rose(inconsistent));                  // R8
endmodule

bind rsc_core_calc rsc_core_chk #(.NUM_ATTR(NUM_ATTR)) u_chk (
    .clk(clk), .rst(rst), .start(start), .done(done),
    .inconsistent(inconsistent), .core_mask(core_mask)
);

// File: tb/rsc_core_calc_tb.sv
`timescale 1ns/1ps
module rsc_core_calc_tb;
    localparam int NO = 8, NA = 8, VW = 2, DW = 1;
    localparam int IW = 3, RW = NA * VW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst, wr_en, start;
    logic [IW-1:0] wr_idx;
    logic [RW-1:0] wr_cond;
    logic [DW-1:0] wr_dec;
    logic [NA-1:0] core_mask;
    logic          done, inconsistent;

    rsc_core_calc #(.NUM_OBJ(NO), .NUM_ATTR(NA), .VAL_W(VW), .DEC_W(DW)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_cond(wr_cond),
        .wr_dec(wr_dec), .start(start), .core_mask(core_mask), .done(done),
        .inconsistent(inconsistent)
    );

    int total = 0, bad = 0;
    logic [RW-1:0] tc [NO];
    logic [DW-1:0] td [NO];
    logic exp_inc;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // pairwise reference: returns core, flags inconsistency
    function automatic logic [NA-1:0] ref_core(output logic inc);
        logic [NA-1:0] c = '0, m;
        inc = 1'b0;
        for (int i = 0; i < NO; i++)
            for (int j = i + 1; j < NO; j++)
                if (td[i] != td[j]) begin
                    for (int a = 0; a < NA; a++)
                        m[a] = tc[i][a*VW +: VW] != tc[j][a*VW +: VW];
                    if (m == '0) inc = 1'b1;
                    else if ($countones(m) == 1) c |= m;
                end
        return c;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; start = 1'b0;
        wr_idx = '0; wr_cond = '0; wr_dec = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < NO; k++) begin tc[k] = '0; td[k] = '0; end
        exp_inc = 1'b0;
    endtask

    task automatic write_row(input int idx, input logic [RW-1:0] c, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_cond = c; wr_dec = d;
        @(negedge clk);
        wr_en = 1'b0;
        tc[idx] = c; td[idx] = d;
    endtask

    task automatic load_and_eval(input string req);
        logic [NA-1:0] e;
        logic inc;
        for (int k = 0; k < NO; k++) write_row(k, tc[k], td[k]);
        e = ref_core(inc);
        exp_inc = exp_inc | inc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({req, " core"}, 32'(core_mask), 32'(e));
        check({req, " R7 done"}, 32'(done), 32'd1);
        check({req, " R8 incons"}, 32'(inconsistent), 32'(exp_inc));
        @(negedge clk);
        check({req, " R7 done low"}, 32'(done), 32'd0);
        check({req, " R7 held"}, 32'(core_mask), 32'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [RW-1:0] base;
        do_reset();
        // R1: reset state, and an all-zero table gives core 0, no inconsistency
        check("R1 core", 32'(core_mask), 0);
        check("R1 done", 32'(done), 0);
        check("R1 incons", 32'(inconsistent), 0);
        start = 1'b1; @(negedge clk); start = 1'b0;
        check("R1 rows zero core", 32'(core_mask), 0);
        check("R1 rows zero incons", 32'(inconsistent), 0);
        @(negedge clk);

        // R5: all decisions equal, wildly different rows -> empty core
        for (int k = 0; k < NO; k++) begin tc[k] = RW'(k * 16'h1111); td[k] = 1'b1; end
        load_and_eval("R5 equal-dec");
        check("R5 core empty", 32'(core_mask), 0);

        // R6: differing pairs always differ on two attributes -> empty core
        for (int k = 0; k < NO; k++) begin
            tc[k] = '0; td[k] = DW'(k & 1);
            if (k & 1) tc[k] = RW'(16'h0005); // attrs 0 and 1 set to 1
        end
        load_and_eval("R6 two-bit");
        check("R6 core empty", 32'(core_mask), 0);

        // R3/R4: single-attribute separations for attrs 2 and 7
        for (int k = 0; k < NO; k++) begin tc[k] = '0; td[k] = '0; end
        tc[1] = RW'(16'h0030); td[1] = 1'b1;  // attr 2 = 3
        tc[2] = RW'(16'h8000); td[2] = 1'b1;  // attr 7 = 2
        tc[3] = RW'(16'h8030); td[3] = 1'b0;
        load_and_eval("R4 hand");

        // R3/R4/R6 structured sweep: base row with one or two attributes changed
        for (int t = 0; t < 300; t++) begin
            base = RW'($urandom);
            for (int k = 0; k < NO; k++) begin
                tc[k] = base;
                for (int n = 0; n <= int'($urandom_range(1, 0)); n++)
                    tc[k][$urandom_range(NA-1, 0)*VW +: VW] = VW'($urandom);
                td[k] = DW'($urandom);
            end
            load_and_eval("R3 R4 sweep");
        end

        // R2: fully random tables
        for (int t = 0; t < 40; t++) begin
            for (int k = 0; k < NO; k++) begin tc[k] = RW'($urandom); td[k] = DW'($urandom); end
            load_and_eval("R2 random");
        end

        // R8: inconsistent pair, plus a singleton on attr 4
        do_reset();
        check("R8 cleared by reset", 32'(inconsistent), 0);
        for (int k = 0; k < NO; k++) begin tc[k] = '0; td[k] = '0; end
        td[5] = 1'b1;                         // same as rows 0..4 -> inconsistent
        tc[6] = RW'(16'h0100); td[6] = 1'b1;  // attr 4 = 1 vs zeros
        tc[7] = RW'(16'h0100);
        load_and_eval("R8 incons");
        check("R8 core attr4", 32'(core_mask), 32'h10);
        // sticky across a consistent evaluation
        for (int k = 0; k < NO; k++) begin tc[k] = '0; td[k] = '0; end
        load_and_eval("R8 sticky");
        check("R8 still set", 32'(inconsistent), 1);

        // R9: write collides with start; old contents used
        do_reset();
        for (int k = 0; k < NO; k++) begin tc[k] = '0; td[k] = '0; end
        tc[1] = RW'(16'h0001); td[1] = 1'b1;  // core = attr 0
        for (int k = 0; k < NO; k++) write_row(k, tc[k], td[k]);
        wr_en = 1'b1; wr_idx = 3'd2; wr_cond = RW'(16'h0004); wr_dec = 1'b1;
        start = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; start = 1'b0;
        check("R9 old table", 32'(core_mask), 32'h01);
        tc[2] = RW'(16'h0004); td[2] = 1'b1;
        @(negedge clk);
        load_and_eval("R9 new table");
        check("R9 new core", 32'(core_mask), 32'h03);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule